// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits between a small register interface and an on-chip flash array and sequences every change to the array. Software picks an operation through mode bits, sets a timing divider, clears the lock bit, and then writes to the array. Depending on the mode, that write programs a byte or a word, programs one word of a block, erases the segment that holds the address, or erases the whole main area. With no mode bit set the array is read-only. The array is a behavioural byte memory inside the block. Erasing drives bytes to 0xFF, and programming can only clear bits, so the stored value becomes the old value AND the written data.

Writes to the control registers carry an 8-bit key in `bus_wdata[15:8]`, which must equal 0xC3. A divider and a power-of-two prescaler set the period of the flash timing clock. An operation is accepted only when that clock lands between 257 kHz and 476 kHz. Each operation lasts a fixed number of timing-clock periods. While it runs, the busy flag is high and the bus is stalled for array accesses and register writes. Register reads stay available so software can poll.

Refused requests leave the array untouched and raise a sticky flag. A locked array, a write with no mode selected, an address past the array, or a wrong key all raise the access-violation flag. A timing clock outside the window raises the configuration-error flag.

Top module: `flash_ctl`

## Requirements
- R1: After reset, MODE (register 0) reads 0x0000, TIME (register 1) reads 0x0000, GUARD (register 2) reads 0x0001 (locked), every array word reads 0xFFFF, busy is 0 and bus_ready is 1.
- R2: A register write whose bus_wdata[15:8] differs from 0xC3 leaves every register unchanged and sets the violation flag (GUARD bit 1). GUARD bits are: 0 lock, 1 violation, 2 configuration error, 3 busy (read-only). Bits 0 to 2 are written directly by a keyed write.
- R3: An array write while locked, or while no mode bit is set, changes no array data, starts nothing, and sets the violation flag.
- R4: The timing period is N = (TIME[7:0] + 1) * 2^MODE[5:4] system cycles. A write is accepted only when 257000 <= CLK_HZ/N <= 476000; at 50 MHz that is 106 <= N <= 194. Otherwise the configuration-error flag (GUARD bit 2) is set, busy stays 0 and the array is unchanged.
- R5: A program operation (MODE bit 0) stores old AND new into each byte lane enabled by bus_be. Lane 0 is the even byte (data bits 7:0), and address bit 0 is ignored.
- R6: busy rises on the edge that accepts the write and stays high for exactly TICKS*N cycles. TICKS is 35 for a program, 21 for a block-program word, and SEG_TICKS or MASS_TICKS for the two erases.
- R7: While busy, bus_ready is low for any array access and any register write, and high for register reads. A GUARD read returns bit 3 set.
- R8: In segment-erase mode (MODE bit 2), a write to any address sets every byte of the segment holding that address to 0xFF and leaves all other segments unchanged. Info segments are 128 bytes from address 0; main segments are 512 bytes and follow them.
- R9: In mass-erase mode (MODE bit 3), every main-area byte is set to 0xFF and the info area is unchanged.
- R10: When several mode bits are set, mass erase wins over segment erase, which wins over block program, which wins over program.
- R11: An array write at or beyond the array size is refused with the violation flag set, and reads there return 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_space | input | 1 | 1 selects the array, 0 the registers |
| bus_addr | input | AW | Byte address (the register index is in bits 1:0) |
| bus_be | input | 2 | Byte lane enables for array writes |
| bus_wdata | input | 16 | Write data; the key sits in bits 15:8 for register writes |
| bus_rdata | output | 16 | Read data, valid combinationally with the request |
| bus_ready | output | 1 | Request is accepted on the next rising edge |
| busy | output | 1 | Operation in progress |
| viol | output | 1 | Sticky access-violation flag |
| cfg_err | output | 1 | Sticky timing-configuration error flag |

## Verification
A wrong busy length appears at the `busy` port as a cycle count that differs from TICKS*N, and the error is visible on the very operation where it occurs. Latching the wrong lane, address or segment shows up on the next array read after busy falls, as a word that is not the AND of old and new or not 0xFFFF. A bad window comparison is caught at the ports on the first write after the timing is set: either `cfg_err` rises or busy starts, and for the edge divisors 104/105 and 193/194 exactly one of the two is correct. A wrong stall decision shows up in the same cycle as a `bus_ready` value that does not match the access type.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

    localparam logic [7:0] CMD_KEY = 8'hC3;

    typedef enum logic [1:0] {
        RA_MODE  = 2'd0,
        RA_TIME  = 2'd1,
        RA_GUARD = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PROG = 3'd1,
        OP_BLK  = 3'd2,
        OP_SEG  = 3'd3,
        OP_MASS = 3'd4
    } op_e;

    typedef struct packed {
        logic mass;
        logic seg;
        logic blk;
        logic prog;
    } mode_bits_t;

    function automatic op_e pick_op(mode_bits_t m);
        if (m.mass)      return OP_MASS;
        else if (m.seg)  return OP_SEG;
        else if (m.blk)  return OP_BLK;
        else if (m.prog) return OP_PROG;
        else             return OP_IDLE;
    endfunction

    function automatic logic key_ok(logic [15:0] w);
        return w[15:8] == CMD_KEY;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import flash_ctl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             busy,
    input  logic             set_viol,
    input  logic             set_cfg_err,
    output mode_bits_t       mode,
    output logic [1:0]       src_sel,
    output logic [DIV_W-1:0] div,
    output logic             lock,
    output logic             viol,
    output logic             cfg_err,
    output logic [15:0]      rd_data
);

    logic key_good;
    assign key_good = key_ok(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= '0;
            src_sel <= '0;
            div     <= '0;
            lock    <= 1'b1;
            viol    <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            if (wr_en && key_good) begin
                case (reg_addr_e'(wr_addr))
                    RA_MODE: begin
                        mode    <= mode_bits_t'(wr_data[3:0]);
                        src_sel <= wr_data[5:4];
                    end
                    RA_TIME:  div <= wr_data[DIV_W-1:0];
                    RA_GUARD: begin
                        lock    <= wr_data[0];
                        viol    <= wr_data[1];
                        cfg_err <= wr_data[2];
                    end
                    default: ;
                endcase
            end
            // Event sets come last so they override a simultaneous clear.
            if ((wr_en && !key_good) || set_viol) viol <= 1'b1;
            if (set_cfg_err) cfg_err <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_MODE:  rd_data = {10'd0, src_sel, mode};
            RA_TIME:  rd_data = 16'(div);
            RA_GUARD: rd_data = {12'd0, busy, cfg_err, viol, lock};
            default:  rd_data = 16'd0;
        endcase
    end

endmodule

// File: rtl/flash_ctl_timer.sv
module flash_ctl_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int MIN_HZ = 257_000,
    parameter int MAX_HZ = 476_000,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] ticks,
    output logic             in_window,
    output logic             done
);

    localparam int NW = DIV_W + 4;

    logic [NW-1:0]    period;
    logic [NW-1:0]    cyc;
    logic [CNT_W-1:0] tick;
    logic [63:0]      slow_prod;
    logic [63:0]      fast_prod;
    logic             period_end;

    assign period = ({{(NW-DIV_W){1'b0}}, div} + NW'(1)) << src_sel;

    // f = CLK_HZ/period lies in [MIN_HZ, MAX_HZ] without a divider.
    assign slow_prod = 64'(period) * 64'(MIN_HZ);
    assign fast_prod = 64'(period) * 64'(MAX_HZ);
    assign in_window = (slow_prod <= 64'(CLK_HZ)) && (fast_prod >= 64'(CLK_HZ));

    assign period_end = (cyc == period - NW'(1));
    assign done       = run && period_end && (tick == ticks - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cyc  <= '0;
            tick <= '0;
        end else if (run) begin
            if (period_end) begin
                cyc  <= '0;
                tick <= tick + CNT_W'(1);
            end else begin
                cyc <= cyc + NW'(1);
            end
        end
    end

endmodule

// File: rtl/flash_ctl_array.sv
module flash_ctl_array
    import flash_ctl_pkg::*;
#(
    parameter int INFO_SEGS  = 2,
    parameter int INFO_SEG_B = 128,
    parameter int MAIN_SEGS  = 2,
    parameter int MAIN_SEG_B = 512,
    parameter int AW         = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data,
    input  logic          commit,
    input  op_e           op,
    input  logic [AW-1:0] op_addr,
    input  logic [1:0]    op_be,
    input  logic [15:0]   op_data
);

    localparam int INFO_B  = INFO_SEGS * INFO_SEG_B;
    localparam int TOTAL_B = INFO_B + MAIN_SEGS * MAIN_SEG_B;

    logic [7:0] mem [TOTAL_B];

    function automatic int seg_of(int a);
        if (a < INFO_B) return a / INFO_SEG_B;
        else            return INFO_SEGS + (a - INFO_B) / MAIN_SEG_B;
    endfunction

    logic [AW-1:0] wbase;
    logic [AW-1:0] rbase;
    int            op_seg;

    assign wbase  = {op_addr[AW-1:1], 1'b0};
    assign rbase  = {rd_addr[AW-1:1], 1'b0};
    assign op_seg = seg_of(int'(op_addr));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TOTAL_B; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            case (op)
                OP_PROG, OP_BLK: begin
                    if (op_be[0]) mem[wbase]          <= mem[wbase] & op_data[7:0];
                    if (op_be[1]) mem[wbase + AW'(1)] <= mem[wbase + AW'(1)] & op_data[15:8];
                end
                OP_SEG: begin
                    for (int i = 0; i < TOTAL_B; i++)
                        if (seg_of(i) == op_seg) mem[i] <= 8'hFF;
                end
                OP_MASS: begin
                    for (int i = INFO_B; i < TOTAL_B; i++) mem[i] <= 8'hFF;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if ({1'b0, rd_addr} < (AW+1)'(TOTAL_B))
            rd_data = {mem[rbase + AW'(1)], mem[rbase]};
        else
            rd_data = 16'hFFFF;
    end

endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
    import flash_ctl_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int MIN_HZ     = 257_000,
    parameter int MAX_HZ     = 476_000,
    parameter int INFO_SEGS  = 2,
    parameter int INFO_SEG_B = 128,
    parameter int MAIN_SEGS  = 2,
    parameter int MAIN_SEG_B = 512,
    parameter int DIV_W      = 8,
    parameter int PROG_TICKS = 35,
    parameter int BLK_TICKS  = 21,
    parameter int SEG_TICKS  = 4819,
    parameter int MASS_TICKS = 5297,
    localparam int TOTAL_B   = INFO_SEGS * INFO_SEG_B + MAIN_SEGS * MAIN_SEG_B,
    localparam int AW        = $clog2(TOTAL_B)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic          bus_space,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_be,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    output logic          bus_ready,
    output logic          busy,
    output logic          viol,
    output logic          cfg_err
);

    localparam int CNT_W = $clog2(max4(PROG_TICKS, BLK_TICKS, SEG_TICKS, MASS_TICKS) + 1);

    mode_bits_t       mode;
    logic [1:0]       src_sel;
    logic [DIV_W-1:0] div;
    logic             lock_q;
    logic             busy_q;
    logic             in_window;
    logic             done;
    logic [15:0]      reg_rd;
    logic [15:0]      arr_rd;

    op_e              op_q;
    logic [AW-1:0]    addr_q;
    logic [1:0]       be_q;
    logic [15:0]      data_q;
    logic [CNT_W-1:0] ticks_sel;

    op_e  req_op;
    logic accept, arr_wr, reg_wr, in_range, refuse_viol, refuse_cfg, start;

    assign bus_ready   = !(busy_q && (bus_space || bus_we));
    assign accept      = bus_req && bus_ready;
    assign arr_wr      = accept && bus_we && bus_space;
    assign reg_wr      = accept && bus_we && !bus_space;
    assign in_range    = {1'b0, bus_addr} < (AW+1)'(TOTAL_B);
    assign req_op      = pick_op(mode);
    assign refuse_viol = arr_wr && (lock_q || (req_op == OP_IDLE) || !in_range);
    assign refuse_cfg  = arr_wr && !refuse_viol && !in_window;
    assign start       = arr_wr && !refuse_viol && in_window;

    flash_ctl_regs #(.DIV_W(DIV_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr),
        .wr_addr     (bus_addr[1:0]),
        .wr_data     (bus_wdata),
        .rd_addr     (bus_addr[1:0]),
        .busy        (busy_q),
        .set_viol    (refuse_viol),
        .set_cfg_err (refuse_cfg),
        .mode        (mode),
        .src_sel     (src_sel),
        .div         (div),
        .lock        (lock_q),
        .viol        (viol),
        .cfg_err     (cfg_err),
        .rd_data     (reg_rd)
    );

    always_comb begin
        case (op_q)
            OP_BLK:  ticks_sel = CNT_W'(BLK_TICKS);
            OP_SEG:  ticks_sel = CNT_W'(SEG_TICKS);
            OP_MASS: ticks_sel = CNT_W'(MASS_TICKS);
            default: ticks_sel = CNT_W'(PROG_TICKS);
        endcase
    end

    flash_ctl_timer #(
        .CLK_HZ (CLK_HZ),
        .MIN_HZ (MIN_HZ),
        .MAX_HZ (MAX_HZ),
        .DIV_W  (DIV_W),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .src_sel   (src_sel),
        .div       (div),
        .start     (start),
        .run       (busy_q),
        .ticks     (ticks_sel),
        .in_window (in_window),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            op_q   <= OP_IDLE;
            addr_q <= '0;
            be_q   <= '0;
            data_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            op_q   <= req_op;
            addr_q <= bus_addr;
            be_q   <= bus_be;
            data_q <= bus_wdata;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

    flash_ctl_array #(
        .INFO_SEGS  (INFO_SEGS),
        .INFO_SEG_B (INFO_SEG_B),
        .MAIN_SEGS  (MAIN_SEGS),
        .MAIN_SEG_B (MAIN_SEG_B),
        .AW         (AW)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (bus_addr),
        .rd_data (arr_rd),
        .commit  (done),
        .op      (op_q),
        .op_addr (addr_q),
        .op_be   (be_q),
        .op_data (data_q)
    );

    assign busy      = busy_q;
    assign bus_rdata = bus_space ? arr_rd : reg_rd;

endmodule

// File: rtl/flash_ctl_chk.sv
module flash_ctl_chk (
    input logic clk,
    input logic rst,
    input logic bus_req,
    input logic bus_we,
    input logic bus_space,
    input logic bus_ready,
    input logic busy,
    input logic cfg_err,
    input logic lock_q,
    input logic in_window
);

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> bus_ready);                                                    // R7
    AST_BUSY_STALLS_ARRAY: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_req && bus_space) |-> !bus_ready);                          // R7
    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_req && bus_we && bus_space && bus_ready));     // R6
    AST_START_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(lock_q));                                         // R3
    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_window));                                       // R4
    AST_REFUSE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_err) |-> !busy);                                               // R4

endmodule

bind flash_ctl flash_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_space (bus_space),
    .bus_ready (bus_ready),
    .busy      (busy),
    .cfg_err   (cfg_err),
    .lock_q    (lock_q),
    .in_window (in_window)
);

// File: tb/flash_ctl_test.sv
module flash_ctl_test;

    localparam logic [7:0] KEY = 8'hC3;
    localparam int SEG_T  = 30;
    localparam int MASS_T = 50;
    localparam int N0     = 106;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_space = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ready, busy, viol, cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_ctl #(.SEG_TICKS(SEG_T), .MASS_TICKS(MASS_T)) uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_space(bus_space), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .busy(busy), .viol(viol), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [1:0]  src;
        logic [7:0]  div;
        logic        ok;
        logic [10:0] addr;
        logic [15:0] data;
    } entry_t;

    localparam entry_t TBL [9] = '{
        '{2'd0, 8'd104, 1'b0, 11'h100, 16'h1234},
        '{2'd0, 8'd105, 1'b1, 11'h102, 16'h5A0F},
        '{2'd0, 8'd193, 1'b1, 11'h104, 16'hF0F0},
        '{2'd0, 8'd194, 1'b0, 11'h106, 16'h0000},
        '{2'd1, 8'd52,  1'b1, 11'h108, 16'h00FF},
        '{2'd1, 8'd51,  1'b0, 11'h10A, 16'h1111},
        '{2'd3, 8'd23,  1'b1, 11'h10C, 16'h8001},
        '{2'd3, 8'd12,  1'b0, 11'h10E, 16'h0000},
        '{2'd2, 8'd26,  1'b1, 11'h110, 16'h7E7E}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_do(input logic sp, input logic we, input logic [10:0] a,
                          input logic [1:0] be, input logic [15:0] wd,
                          output logic [15:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_space = sp;
        bus_addr = a; bus_be = be; bus_wdata = wd;
        #1;
        while (!bus_ready) begin @(negedge clk); #1; end
        rd = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] r, input logic [7:0] v);
        logic [15:0] d;
        bus_do(1'b0, 1'b1, {9'd0, r}, 2'b11, {KEY, v}, d);
    endtask

    task automatic rreg(input logic [1:0] r, output logic [15:0] v);
        bus_do(1'b0, 1'b0, {9'd0, r}, 2'b11, 16'h0, v);
    endtask

    task automatic rarr(input logic [10:0] a, output logic [15:0] v);
        bus_do(1'b1, 1'b0, a, 2'b11, 16'h0, v);
    endtask

    // Busy cycles seen at negedges after acceptance, until busy falls.
    task automatic wait_idle(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            n++;
        end
    endtask

    task automatic warr(input logic [10:0] a, input logic [1:0] be,
                        input logic [15:0] d, output int n);
        logic [15:0] x;
        bus_do(1'b1, 1'b1, a, be, d, x);
        wait_idle(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 ready", bus_ready, 1);
        rreg(2'd0, v); chk("R1 mode", v, 16'h0000);
        rreg(2'd1, v); chk("R1 time", v, 16'h0000);
        rreg(2'd2, v); chk("R1 guard", v, 16'h0001);
        rarr(11'h000, v); chk("R1 array", v, 16'hFFFF);
        rarr(11'h4FE, v); chk("R1 array top", v, 16'hFFFF);

        // R2 bad key
        bus_do(1'b0, 1'b1, 11'd0, 2'b11, 16'h0001, v);
        rreg(2'd0, v); chk("R2 mode kept", v, 16'h0000);
        rreg(2'd2, v); chk("R2 viol set", v, 16'h0003);
        wreg(2'd2, 8'h01);
        rreg(2'd2, v); chk("R2 viol cleared", v, 16'h0001);

        // R3 locked write and read-mode write
        wreg(2'd0, 8'h01);
        wreg(2'd1, 8'd105);
        warr(11'h020, 2'b11, 16'h0000, n);
        chk("R3 locked no busy", n, 0);
        rreg(2'd2, v); chk("R3 locked viol", v, 16'h0003);
        rarr(11'h020, v); chk("R3 locked data", v, 16'hFFFF);
        wreg(2'd2, 8'h00);
        wreg(2'd0, 8'h00);
        warr(11'h020, 2'b11, 16'h0000, n);
        chk("R3 readmode no busy", n, 0);
        chk("R3 readmode viol", viol, 1);
        rarr(11'h020, v); chk("R3 readmode data", v, 16'hFFFF);
        wreg(2'd2, 8'h00);

        // R4 / R6 window table
        foreach (TBL[i]) begin
            int period;
            period = (int'(TBL[i].div) + 1) << TBL[i].src;
            wreg(2'd1, TBL[i].div);
            wreg(2'd0, {2'b00, TBL[i].src, 4'b0001});
            warr(TBL[i].addr, 2'b11, TBL[i].data, n);
            chk($sformatf("R4 cfg_err entry %0d", i), cfg_err, !TBL[i].ok);
            chk($sformatf("R6 busy length entry %0d", i), n, TBL[i].ok ? 35 * period : 0);
            rarr(TBL[i].addr, v);
            chk($sformatf("R4 data entry %0d", i), v, TBL[i].ok ? TBL[i].data : 16'hFFFF);
            wreg(2'd2, 8'h00);
        end

        wreg(2'd1, 8'd105);
        wreg(2'd0, 8'h01);

        // R5 AND rule and lanes
        warr(11'h200, 2'b11, 16'hF0F0, n);
        warr(11'h200, 2'b11, 16'h3CFF, n);
        rarr(11'h200, v); chk("R5 and rule", v, 16'h30F0);
        warr(11'h210, 2'b01, 16'h0000, n);
        rarr(11'h210, v); chk("R5 low lane", v, 16'hFF00);
        warr(11'h213, 2'b10, 16'h1200, n);
        rarr(11'h212, v); chk("R5 high lane odd addr", v, 16'h12FF);

        // R7 stalls while busy
        bus_do(1'b1, 1'b1, 11'h220, 2'b11, 16'hFFFE, v);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_space = 1'b1; #1;
        chk("R7 array read stalled", bus_ready, 0);
        bus_space = 1'b0; bus_addr = 11'd2; #1;
        chk("R7 reg read ready", bus_ready, 1);
        chk("R7 busy bit", bus_rdata[3], 1);
        bus_we = 1'b1; bus_wdata = {KEY, 8'h01}; #1;
        chk("R7 reg write stalled", bus_ready, 0);
        bus_req = 1'b0; bus_we = 1'b0;
        wait_idle(n);
        rreg(2'd2, v); chk("R7 guard untouched", v, 16'h0000);

        // R6 block program, R10 blk over prog
        wreg(2'd0, 8'h02);
        warr(11'h230, 2'b11, 16'hAAAA, n);
        chk("R6 block length", n, 21 * N0);
        rarr(11'h230, v); chk("R6 block data", v, 16'hAAAA);
        wreg(2'd0, 8'h03);
        warr(11'h232, 2'b11, 16'h5555, n);
        chk("R10 blk over prog", n, 21 * N0);

        // R8 segment erase
        wreg(2'd0, 8'h01);
        warr(11'h010, 2'b11, 16'h0000, n);
        warr(11'h090, 2'b11, 16'h0000, n);
        warr(11'h300, 2'b11, 16'h0000, n);
        wreg(2'd0, 8'h04);
        warr(11'h005, 2'b11, 16'h1234, n);
        chk("R8 seg erase length", n, SEG_T * N0);
        rarr(11'h010, v); chk("R8 info seg erased", v, 16'hFFFF);
        rarr(11'h090, v); chk("R8 next info kept", v, 16'h0000);
        rarr(11'h102, v); chk("R8 main kept", v, 16'h5A0F);
        warr(11'h2FE, 2'b11, 16'h0000, n);
        rarr(11'h102, v); chk("R8 main seg erased", v, 16'hFFFF);
        rarr(11'h200, v); chk("R8 main seg erased b", v, 16'hFFFF);
        rarr(11'h300, v); chk("R8 next main kept", v, 16'h0000);

        // R9 mass erase via R10 priority (mass over seg)
        wreg(2'd0, 8'h0C);
        warr(11'h040, 2'b11, 16'h0000, n);
        chk("R10 mass over seg length", n, MASS_T * N0);
        rarr(11'h300, v); chk("R9 main erased", v, 16'hFFFF);
        rarr(11'h090, v); chk("R9 info kept", v, 16'h0000);
        rarr(11'h040, v); chk("R9 info addr untouched", v, 16'hFFFF);

        // R11 out of range
        wreg(2'd0, 8'h01);
        warr(11'h514, 2'b11, 16'h0000, n);
        chk("R11 no busy", n, 0);
        chk("R11 viol", viol, 1);
        rarr(11'h514, v); chk("R11 read", v, 16'hFFFF);

        wreg(2'd2, 8'h01);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule